// File: doc/BRIEF.md
# SAR Converter Serial Output Emulator

This block is a synthesizable model of the digital interface of an 18-bit successive-approximation converter. The converter runs in chip-select mode with a busy indicator, and its serial data input is treated as held high. A host raises the convert strobe to start a sample. The block then keeps its serial data line released for a programmable number of clock cycles. When the conversion ends it drives the line low, and a host with a pull-up sees that edge as an interrupt. The host then clocks the result out, MSB first, with falling edges of the serial clock. The tri-state is modelled as a data bit plus an output-enable.

The block samples the strobe and the serial clock in the system clock domain and detects their edges there. The sample word comes from the testbench and is captured when the conversion starts. The conversion length is also loaded at that point. When the strobe is still high at the end of a conversion, the block does not drive the line. It raises a missed-indication flag instead.

Top module: `sar_sdo_emu`

## Requirements
- R1: A rising edge of `cnv` while no conversion is running starts a conversion. `sdo_oe` is 0 after the clock edge that detects it, and `missed` is cleared at that edge.
- R2: A conversion lasts max(`conv_cycles`,1) clock edges after the detecting edge. `sdo_oe` stays 0 throughout, and `cnv` toggles or rising edges during that time neither restart nor shorten it.
- R3: At the end of a conversion with `cnv` low, `sdo_oe` becomes 1 and the first level driven on `sdo` is 0.
- R4: During readout, the k-th detected falling edge of `sck` (k = 1..18) makes `sdo` show result bit 18-k, so bit 17 (the MSB) comes first.
- R5: The 19th detected falling edge of `sck` sets `sdo_oe` to 0 and ends the readout.
- R6: A rising edge of `cnv` during readout sets `sdo_oe` to 0 at the edge that detects it and starts a new conversion.
- R7: If `cnv` is high at the end of a conversion, `sdo_oe` stays 0 and `missed` goes to 1 until the next conversion starts.
- R8: Falling edges of `sck` during a conversion are ignored. Readout still begins with the low level, and the first readout edge gives the MSB.
- R9: `sample` is captured at the start of a conversion, so changes to it afterwards do not alter the bits that are read out.
- R10: After reset, `sdo_oe`, `sdo` and `missed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Convert strobe; its rising edge starts a conversion |
| sck | input | 1 | Serial clock; its falling edges advance the readout |
| conv_cycles | input | 16 | Conversion length in clock cycles, loaded at the start (0 acts as 1) |
| sample | input | 18 | Result word captured at the start of a conversion |
| sdo | output | 1 | Serial data level, meaningful while sdo_oe is 1 |
| sdo_oe | output | 1 | 1 when the data line is driven, 0 when released |
| missed | output | 1 | Set when a conversion ends with cnv high |

## Verification
The hardest case to reach from the ports is a conversion that is disturbed while it runs. In that case `cnv` pulses and `sck` falls before the end time, and the block must neither restart nor advance its bit count. The stimulus reaches this case with a vector whose flag toggles both lines on alternate cycles inside the conversion window. It then releases them just before the expected end edge and checks that the busy-low level and the full MSB-first word still appear on time. A second hard case is a new convert edge cut into a partial readout, which the directed tests provoke after five bits.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  // Effective conversion length: a zero count still takes one edge.
  function automatic logic [15:0] eff_len(input logic [15:0] n);
    return (n == 16'd0) ? 16'd1 : n;
  endfunction

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic pulse
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = d & ~d_q;
    end else begin : g_fall
      assign pulse = ~d & d_q;
    end
  endgenerate
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cycles,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= (cycles == '0) ? CW'(1) : cycles;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == CW'(1)) busy <= 1'b0;
      else               cnt  <= cnt - CW'(1);
    end
  end

  assign done = busy && (cnt == CW'(1));
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
  parameter int DW = 18,
  localparam int IW = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          advance,
  output logic          bit_out,
  output logic          last_fall,
  output logic [IW-1:0] falls
);
  localparam logic [IW-1:0] LAST = IW'(DW);

  logic [DW-1:0] word;
  logic [IW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      falls <= '0;
    end else if (load) begin
      word  <= din;
      falls <= '0;
    end else if (advance && falls <= LAST) begin
      falls <= falls + IW'(1);
    end
  end

  assign pos       = LAST - falls;
  assign bit_out   = (falls == '0 || falls > LAST) ? 1'b0 : word[pos];
  assign last_fall = advance && (falls == LAST);
endmodule

// File: rtl/sar_sdo_emu.sv
module sar_sdo_emu #(
  parameter int DW = 18,
  parameter int CW = 16,
  localparam int IW = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnv,
  input  logic          sck,
  input  logic [CW-1:0] conv_cycles,
  input  logic [DW-1:0] sample,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          missed
);
  import sar_emu_pkg::*;

  phase_e        phase;
  logic          cnv_rise;
  logic          sck_fall;
  logic          conv_start;
  logic          conv_busy;
  logic          conv_done;
  logic          read_adv;
  logic          read_last;
  logic          shift_bit;
  logic [IW-1:0] fall_cnt;

  sar_edge_det #(.RISE(1'b1)) u_cnv_edge (
    .clk(clk), .rst_n(rst_n), .d(cnv), .pulse(cnv_rise)
  );

  sar_edge_det #(.RISE(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .d(sck), .pulse(sck_fall)
  );

  assign conv_start = cnv_rise && !conv_busy;

  sar_conv_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .cycles(conv_cycles),
    .busy(conv_busy), .done(conv_done)
  );

  assign read_adv = sck_fall && (phase == PH_READ);

  sar_shift_out #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(conv_start), .din(sample),
    .advance(read_adv), .bit_out(shift_bit), .last_fall(read_last),
    .falls(fall_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      missed <= 1'b0;
    end else if (conv_start) begin
      phase  <= PH_CONV;
      missed <= 1'b0;
    end else begin
      unique case (phase)
        PH_CONV: if (conv_done) begin
          if (cnv) begin
            phase  <= PH_IDLE;
            missed <= 1'b1;
          end else begin
            phase <= PH_READ;
          end
        end
        PH_READ: if (read_last) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sdo_oe = (phase == PH_READ);
  assign sdo    = sdo_oe && shift_bit;
endmodule

// File: rtl/sar_sdo_emu_chk.sv
module sar_sdo_emu_chk #(
  parameter int DW = 18,
  localparam int IW = $clog2(DW + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnv,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          missed,
  input logic          conv_start,
  input logic          conv_busy,
  input logic          conv_done,
  input logic          sck_fall,
  input logic [IW-1:0] fall_cnt
);
  localparam logic [IW-1:0] LAST = IW'(DW);

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (!sdo_oe && conv_busy && !missed)); // R1
  AST_CONV_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> !sdo_oe); // R2
  AST_FIRST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo); // R3
  AST_DONE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cnv) |=> sdo_oe); // R3
  AST_FALL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && sck_fall && !conv_start && fall_cnt < LAST) |=> (fall_cnt == $past(fall_cnt) + IW'(1))); // R4
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && sck_fall && !conv_start && fall_cnt == LAST) |=> !sdo_oe); // R5
  AST_CNV_CUTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && conv_start) |=> !sdo_oe); // R6
  AST_MISSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && cnv) |=> (missed && !sdo_oe)); // R7
  AST_SCK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> (fall_cnt == '0)); // R8
endmodule

bind sar_sdo_emu sar_sdo_emu_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdo(sdo), .sdo_oe(sdo_oe),
  .missed(missed), .conv_start(conv_start), .conv_busy(conv_busy),
  .conv_done(conv_done), .sck_fall(sck_fall), .fall_cnt(fall_cnt)
);

// File: tb/sar_sdo_emu_tb_top.sv
module sar_sdo_emu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv = 1'b0;
  logic        sck = 1'b1;
  logic [15:0] conv_cycles = 16'd0;
  logic [17:0] sample = 18'd0;
  logic        sdo, sdo_oe, missed;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sar_sdo_emu dut_i (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .conv_cycles(conv_cycles),
    .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe), .missed(missed)
  );

  // fields: [35:18] word, [17:2] length, [1] keep cnv high, [0] disturb lines
  localparam logic [35:0] VEC [0:6] = '{
    {18'h2AAAA, 16'd5,  1'b0, 1'b0},
    {18'h15555, 16'd1,  1'b0, 1'b0},
    {18'h3FFFF, 16'd0,  1'b0, 1'b0},
    {18'h00001, 16'd12, 1'b0, 1'b1},
    {18'h20000, 16'd4,  1'b1, 1'b0},
    {18'h1C3A5, 16'd9,  1'b0, 1'b1},
    {18'h00000, 16'd3,  1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [17:0] s, input logic [15:0] n, input bit hold,
                       input string req);
    @(negedge clk);
    sample = s; conv_cycles = n; cnv = 1'b1;
    @(negedge clk);
    check(!sdo_oe, req, int'(sdo_oe), 0);
    check(!missed, "R1 R7 flag cleared", int'(missed), 0);
    if (!hold) cnv = 1'b0;
    sample = ~s;  // R9: must not reach the readout
  endtask

  task automatic wait_conv(input logic [15:0] n, input bit junk);
    int eff = (n == 16'd0) ? 1 : int'(n);
    for (int i = 1; i < eff; i++) begin
      check(!sdo_oe, "R2 released in conversion", int'(sdo_oe), 0);
      if (junk) begin
        sck = (i % 2 == 1) ? 1'b0 : 1'b1;  // R8 stray falls
        cnv = (i % 2 == 0);                // R2 stray rises
      end
      @(negedge clk);
    end
    check(!sdo_oe, "R2 released before end", int'(sdo_oe), 0);
    if (junk) cnv = 1'b0;
    sck = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_bits(input logic [17:0] s, input int nb);
    for (int k = 1; k <= nb; k++) begin
      sck = 1'b0;
      @(negedge clk);
      if (k <= 18) begin
        check(sdo_oe && sdo == s[18-k], "R4 R9 bit order", int'({sdo_oe, sdo}),
              int'({1'b1, s[18-k]}));
      end else begin
        check(!sdo_oe, "R5 release on edge 19", int'(sdo_oe), 0);
      end
      sck = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sdo_oe && !sdo && !missed, "R10 reset state", int'({sdo_oe, sdo, missed}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sdo_oe && !missed, "R10 after reset", int'({sdo_oe, missed}), 0);

    for (int v = 0; v < 7; v++) begin
      logic [17:0] s;
      logic [15:0] n;
      bit hold, junk;
      s = VEC[v][35:18]; n = VEC[v][17:2]; hold = VEC[v][1]; junk = VEC[v][0];
      start(s, n, hold, "R1 start releases");
      wait_conv(n, junk && !hold);
      if (hold) begin
        check(!sdo_oe, "R7 no drive with cnv high", int'(sdo_oe), 0);
        check(missed, "R7 missed flag set", int'(missed), 1);
        cnv = 1'b0;
        repeat (2) @(negedge clk);
        check(missed && !sdo_oe, "R7 flag held", int'({missed, sdo_oe}), 2);
      end else begin
        check(sdo_oe && !sdo, "R3 busy-low indication", int'({sdo_oe, sdo}), 2);
        read_bits(s, 19);
      end
    end

    // R6: convert edge in the middle of a readout
    start(18'h2C0F3, 16'd4, 1'b0, "R1 start");
    wait_conv(16'd4, 1'b0);
    check(sdo_oe && !sdo, "R3 busy-low indication", int'({sdo_oe, sdo}), 2);
    read_bits(18'h2C0F3, 5);
    start(18'h13579, 16'd3, 1'b0, "R6 cnv cuts readout");
    wait_conv(16'd3, 1'b0);
    check(sdo_oe && !sdo, "R6 R3 new conversion ends low", int'({sdo_oe, sdo}), 2);
    read_bits(18'h13579, 19);

    // R5: extra falls after release keep the line released
    sck = 1'b0;
    @(negedge clk);
    check(!sdo_oe, "R5 stays released", int'(sdo_oe), 0);
    sck = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule